// File: doc/BRIEF.md
# Crash-Triggered Circular Frame Recorder

This block keeps the most recent video frames of a camera in a pair of external asynchronous 16-bit SRAM chips. The chips form one ring of whole-frame slots. Pixel words arrive on a ready/valid input, and each one is written with a three-cycle SRAM write: address and data are set up, the write-enable pulse follows, and then a hold cycle. After the last slot the write position wraps to slot 0, so new frames overwrite the oldest one.

A crash detector raises a single trigger line. From then on the block accepts no more pixels. A pixel write that is already under way is completed. The block then freezes the ring and works out which slot holds the oldest intact frame and how many intact frames there are. A frame that was only partly written when the trigger arrived is dropped. If the ring had already wrapped, the slot holding that partial frame has also lost its old content, so it is dropped as well.

The block then reads the frames back from oldest to newest. It sends them as a byte stream with ready/valid handshaking to a downstream link that stores them in flash. Each frame starts with a two-byte header.

Top module: `frame_recorder`

## Requirements
- R1: After reset the block shows pix_ready=1 and out_valid=0. Both chips are deselected (sram_ce1_n=2'b11, sram_ce2=2'b00), and sram_we_n=1 and sram_oe_n=1.
- R2: Each accepted pixel (pix_valid and pix_ready high at a clock edge) causes exactly one write. The write has one setup cycle, a write-enable low pulse of exactly one cycle, and one hold cycle. sram_addr and sram_dq are stable over all three cycles. pix_ready is low during those three cycles.
- R3: Word w of slot s is stored at global word address s*FRAME_WORDS+w. Global address bit ADDR_W selects the chip: chip c is enabled by sram_ce1_n[c]=0 together with sram_ce2[c]=1. The low ADDR_W bits appear on sram_addr. At most one chip is enabled at a time, and every write enables exactly one chip.
- R4: Slots fill in the order 0, 1, …, NUM_SLOTS-1 and then wrap to slot 0, overwriting the oldest frame.
- R5: Once crash has been high at a clock edge, pix_ready stays low until reset. A write already in progress at that moment completes, and no further write pulse occurs.
- R6: If fewer than NUM_SLOTS frames were completed before the trigger, readout starts at slot 0 and covers exactly the completed frames. A trailing partial frame is not sent.
- R7: If the ring has wrapped and no frame is in progress at the trigger, readout covers all NUM_SLOTS frames. It starts at the slot the next frame would have been written to.
- R8: If the ring has wrapped and a frame is in progress at the trigger, readout covers NUM_SLOTS-1 frames. It starts at the slot after the one being written.
- R9: Each replayed frame is sent as a fixed sequence. First comes the byte HDR_MARK (default 8'hA5). Next comes a byte holding the frame's age rank (0 for the oldest, counting up). Then come its FRAME_WORDS pixels in address order, each as its high byte followed by its low byte.
- R10: A byte moves only on a clock edge where out_valid and out_ready are both high. While out_valid=1 and out_ready=0, out_valid and out_data hold their values.
- R11: sram_oe_n is low only while sram_we_n is high and no pixel can be accepted. The data bus is released to the SRAM during reads.
- R12: After the last byte of the last replayed frame, out_valid stays low until reset. If no frame was complete at the trigger, no byte is sent at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Block can take a pixel word |
| pix_data | input | 16 | Pixel word |
| crash | input | 1 | Crash trigger, active high |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| sram_addr | output | ADDR_W | Word address shared by both chips |
| sram_ce1_n | output | 2 | Active-low chip enable, one bit per chip |
| sram_ce2 | output | 2 | Active-high chip enable, one bit per chip |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bhe_n | output | 1 | Upper byte enable, held active (0) |
| sram_ble_n | output | 1 | Lower byte enable, held active (0) |
| sram_dq | inout | 16 | SRAM data bus |

## Verification
The capture-then-replay path is exercised with pixel counts chosen around the ring's state at the trigger. These cover no frame at all, a lone partial frame, a few frames before the ring wraps, exactly one full ring, a full ring plus a partial frame, and two full wraps with and without a partial frame. Comparing each case's byte stream shows whether the block picks the right start slot, whether it counts frames correctly, and whether it drops frames it should drop. Every pixel value is distinct, so a wrong address, a swapped chip or a wrong byte order shows up as a payload mismatch. One directed test raises the trigger while a write is in flight, to tell a completed write apart from an abandoned one. The downstream ready line is stalled in a repeating pattern to expose bytes that are lost or changed during back-pressure.

// File: rtl/frec_pkg.sv
package frec_pkg;

   localparam int PIX_W = 16;

   typedef enum logic [1:0] {
      WP_IDLE,
      WP_SETUP,
      WP_PULSE,
      WP_HOLD
   } wr_phase_e;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_HDR_A,
      DS_HDR_B,
      DS_ADDR,
      DS_LATCH,
      DS_HI,
      DS_LO,
      DS_END
   } dump_state_e;

endpackage

// File: rtl/frec_slot_ring.sv
module frec_slot_ring #(
   parameter int FRAME_WORDS = 76800,
   parameter int NUM_SLOTS   = 27,
   parameter int GA_W        = 21,
   localparam int CNT_W      = $clog2(NUM_SLOTS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_done,
   input  logic             freeze,
   output logic [GA_W-1:0]  wr_addr,
   output logic [GA_W-1:0]  snap_base,
   output logic [CNT_W-1:0] snap_count
);

   localparam int WORD_W = $clog2(FRAME_WORDS);
   localparam logic [GA_W-1:0]   STEP      = GA_W'(FRAME_WORDS);
   localparam logic [GA_W-1:0]   LAST_BASE = GA_W'((NUM_SLOTS - 1) * FRAME_WORDS);
   localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(FRAME_WORDS - 1);
   localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(NUM_SLOTS);

   logic [GA_W-1:0]   base_q;
   logic [GA_W-1:0]   next_base;
   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  filled_q;
   logic              ring_full;
   logic              partial;

   assign next_base = (base_q == LAST_BASE) ? '0 : base_q + STEP;
   assign wr_addr   = base_q + GA_W'(word_q);
   assign ring_full = (filled_q == FULL_CNT);
   assign partial   = (word_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         word_q   <= '0;
         filled_q <= '0;
      end else if (word_done) begin
         if (word_q == LAST_WORD) begin
            word_q <= '0;
            base_q <= next_base;
            if (!ring_full) filled_q <= filled_q + CNT_W'(1);
         end else begin
            word_q <= word_q + WORD_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_base  <= '0;
         snap_count <= '0;
      end else if (freeze) begin
         if (!ring_full) begin
            snap_base  <= '0;
            snap_count <= filled_q;
         end else if (partial) begin
            snap_base  <= next_base;
            snap_count <= FULL_CNT - CNT_W'(1);
         end else begin
            snap_base  <= base_q;
            snap_count <= FULL_CNT;
         end
      end
   end

endmodule

// File: rtl/frec_sram_port.sv
module frec_sram_port
   import frec_pkg::*;
#(
   parameter int ADDR_W  = 20,
   localparam int GA_W   = ADDR_W + 1
)(
   input  wr_phase_e          wr_phase,
   input  logic [GA_W-1:0]    wr_addr,
   input  logic [PIX_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [GA_W-1:0]    rd_addr,
   output logic [PIX_W-1:0]   rd_data,
   output logic [ADDR_W-1:0]  sram_addr,
   output logic [1:0]         sram_ce1_n,
   output logic [1:0]         sram_ce2,
   output logic               sram_we_n,
   output logic               sram_oe_n,
   output logic               sram_bhe_n,
   output logic               sram_ble_n,
   inout  wire  [PIX_W-1:0]   sram_dq
);

   logic            wr_act;
   logic            bus_act;
   logic [GA_W-1:0] acc_addr;

   assign wr_act   = (wr_phase != WP_IDLE);
   assign bus_act  = wr_act | rd_en;
   assign acc_addr = wr_act ? wr_addr : rd_addr;

   for (genvar c = 0; c < 2; c++) begin : g_chip
      logic sel;
      assign sel           = bus_act && (acc_addr[ADDR_W] == 1'(c));
      assign sram_ce1_n[c] = !sel;
      assign sram_ce2[c]   = sel;
   end

   assign sram_addr  = acc_addr[ADDR_W-1:0];
   assign sram_we_n  = (wr_phase != WP_PULSE);
   assign sram_oe_n  = !rd_en;
   assign sram_bhe_n = 1'b0;
   assign sram_ble_n = 1'b0;
   assign sram_dq    = wr_act ? wr_data : 'z;
   assign rd_data    = sram_dq;

endmodule

// File: rtl/frec_dump.sv
module frec_dump
   import frec_pkg::*;
#(
   parameter int         FRAME_WORDS = 76800,
   parameter int         NUM_SLOTS   = 27,
   parameter int         GA_W        = 21,
   parameter logic [7:0] HDR_MARK    = 8'hA5,
   localparam int        CNT_W       = $clog2(NUM_SLOTS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [GA_W-1:0]  start_base,
   input  logic [CNT_W-1:0] frame_count,
   input  logic [PIX_W-1:0] rd_data,
   output logic             rd_en,
   output logic [GA_W-1:0]  rd_addr,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [7:0]       out_data
);

   localparam int WORD_W = $clog2(FRAME_WORDS);
   localparam logic [GA_W-1:0]   STEP      = GA_W'(FRAME_WORDS);
   localparam logic [GA_W-1:0]   LAST_BASE = GA_W'((NUM_SLOTS - 1) * FRAME_WORDS);
   localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(FRAME_WORDS - 1);

   dump_state_e       state_q;
   logic [GA_W-1:0]   base_q;
   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  left_q;
   logic [7:0]        rank_q;
   logic [PIX_W-1:0]  pix_q;
   logic              fire;

   assign rd_addr = base_q + GA_W'(word_q);
   assign rd_en   = (state_q == DS_ADDR) || (state_q == DS_LATCH);
   assign fire    = out_valid && out_ready;

   always_comb begin
      out_valid = 1'b0;
      out_data  = 8'h00;
      case (state_q)
         DS_HDR_A: begin out_valid = 1'b1; out_data = HDR_MARK;    end
         DS_HDR_B: begin out_valid = 1'b1; out_data = rank_q;      end
         DS_HI:    begin out_valid = 1'b1; out_data = pix_q[15:8]; end
         DS_LO:    begin out_valid = 1'b1; out_data = pix_q[7:0];  end
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         base_q  <= '0;
         word_q  <= '0;
         left_q  <= '0;
         rank_q  <= '0;
         pix_q   <= '0;
      end else begin
         case (state_q)
            DS_IDLE: if (start) begin
               base_q  <= start_base;
               left_q  <= frame_count;
               word_q  <= '0;
               rank_q  <= '0;
               state_q <= (frame_count == '0) ? DS_END : DS_HDR_A;
            end
            DS_HDR_A: if (fire) state_q <= DS_HDR_B;
            DS_HDR_B: if (fire) state_q <= DS_ADDR;
            DS_ADDR:  state_q <= DS_LATCH;
            DS_LATCH: begin
               pix_q   <= rd_data;
               state_q <= DS_HI;
            end
            DS_HI: if (fire) state_q <= DS_LO;
            DS_LO: if (fire) begin
               if (word_q == LAST_WORD) begin
                  word_q  <= '0;
                  rank_q  <= rank_q + 8'd1;
                  left_q  <= left_q - CNT_W'(1);
                  base_q  <= (base_q == LAST_BASE) ? '0 : base_q + STEP;
                  state_q <= (left_q == CNT_W'(1)) ? DS_END : DS_HDR_A;
               end else begin
                  word_q  <= word_q + WORD_W'(1);
                  state_q <= DS_ADDR;
               end
            end
            default: state_q <= DS_END;
         endcase
      end
   end

endmodule

// File: rtl/frame_recorder.sv
module frame_recorder
   import frec_pkg::*;
#(
   parameter int         ADDR_W      = 20,
   parameter int         FRAME_WORDS = 76800,
   parameter int         NUM_SLOTS   = 27,
   parameter logic [7:0] HDR_MARK    = 8'hA5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   output logic              pix_ready,
   input  logic [15:0]       pix_data,
   input  logic              crash,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [1:0]        sram_ce1_n,
   output logic [1:0]        sram_ce2,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic              sram_bhe_n,
   output logic              sram_ble_n,
   inout  wire  [15:0]       sram_dq
);

   localparam int GA_W  = ADDR_W + 1;
   localparam int CNT_W = $clog2(NUM_SLOTS + 1);

   if (FRAME_WORDS < 2) begin : g_bad_frame
      $error("frame_recorder: FRAME_WORDS must be at least 2");
   end
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("frame_recorder: NUM_SLOTS must be at least 2");
   end
   if (ADDR_W < 2 || ADDR_W > 28) begin : g_bad_addr
      $error("frame_recorder: ADDR_W out of range");
   end
   if (longint'(NUM_SLOTS) * longint'(FRAME_WORDS) > (longint'(1) << GA_W)) begin : g_bad_fit
      $error("frame_recorder: ring does not fit in two chips");
   end

   wr_phase_e        wstate_q;
   logic [PIX_W-1:0] wdata_q;
   logic [GA_W-1:0]  waddr_q;
   logic [GA_W-1:0]  ring_addr;
   logic [GA_W-1:0]  snap_base;
   logic [CNT_W-1:0] snap_count;
   logic [GA_W-1:0]  rd_addr;
   logic [PIX_W-1:0] rd_data;
   logic             rd_en;
   logic             crash_seen_q;
   logic             frozen_q;
   logic             freeze;
   logic             freeze_q;
   logic             accept;
   logic             word_done;

   assign pix_ready = (wstate_q == WP_IDLE) && !frozen_q && !crash && !crash_seen_q;
   assign accept    = pix_valid && pix_ready;
   assign word_done = (wstate_q == WP_HOLD);
   assign freeze    = (wstate_q == WP_IDLE) && !frozen_q && (crash || crash_seen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wstate_q     <= WP_IDLE;
         wdata_q      <= '0;
         waddr_q      <= '0;
         crash_seen_q <= 1'b0;
         frozen_q     <= 1'b0;
         freeze_q     <= 1'b0;
      end else begin
         crash_seen_q <= crash_seen_q | crash;
         freeze_q     <= freeze;
         if (freeze) frozen_q <= 1'b1;
         case (wstate_q)
            WP_IDLE: if (accept) begin
               wdata_q  <= pix_data;
               waddr_q  <= ring_addr;
               wstate_q <= WP_SETUP;
            end
            WP_SETUP: wstate_q <= WP_PULSE;
            WP_PULSE: wstate_q <= WP_HOLD;
            default:  wstate_q <= WP_IDLE;
         endcase
      end
   end

   frec_slot_ring #(
      .FRAME_WORDS (FRAME_WORDS),
      .NUM_SLOTS   (NUM_SLOTS),
      .GA_W        (GA_W)
   ) i_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_done  (word_done),
      .freeze     (freeze),
      .wr_addr    (ring_addr),
      .snap_base  (snap_base),
      .snap_count (snap_count)
   );

   frec_dump #(
      .FRAME_WORDS (FRAME_WORDS),
      .NUM_SLOTS   (NUM_SLOTS),
      .GA_W        (GA_W),
      .HDR_MARK    (HDR_MARK)
   ) i_dump (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (freeze_q),
      .start_base  (snap_base),
      .frame_count (snap_count),
      .rd_data     (rd_data),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .out_ready   (out_ready),
      .out_valid   (out_valid),
      .out_data    (out_data)
   );

   frec_sram_port #(
      .ADDR_W (ADDR_W)
   ) i_port (
      .wr_phase   (wstate_q),
      .wr_addr    (waddr_q),
      .wr_data    (wdata_q),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .sram_addr  (sram_addr),
      .sram_ce1_n (sram_ce1_n),
      .sram_ce2   (sram_ce2),
      .sram_we_n  (sram_we_n),
      .sram_oe_n  (sram_oe_n),
      .sram_bhe_n (sram_bhe_n),
      .sram_ble_n (sram_ble_n),
      .sram_dq    (sram_dq)
   );

endmodule

// File: rtl/frame_recorder_chk.sv
module frame_recorder_chk #(
   parameter int ADDR_W = 20
)(
   input logic              clk,
   input logic              rst_n,
   input logic              crash,
   input logic              pix_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic [ADDR_W-1:0] sram_addr,
   input logic [15:0]       sram_dq,
   input logic [1:0]        sram_ce1_n,
   input logic [1:0]        sram_ce2,
   input logic              sram_we_n,
   input logic              sram_oe_n
);

   AST_WE_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $stable(sram_addr) && $stable(sram_dq)); // R2

   AST_WE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> $stable(sram_addr) && $stable(sram_dq)); // R2

   AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |=> sram_we_n); // R2

   AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sram_ce1_n)); // R3

   AST_WE_HAS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> $countones(sram_ce2) == 1); // R3

   AST_NO_READY_AFTER_CRASH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(crash) |-> !pix_ready); // R5

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

   AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> sram_we_n); // R11

   AST_NO_READ_WHILE_RECORDING: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !pix_ready); // R11

endmodule

bind frame_recorder frame_recorder_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .crash      (crash),
   .pix_ready  (pix_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .sram_addr  (sram_addr),
   .sram_dq    (sram_dq),
   .sram_ce1_n (sram_ce1_n),
   .sram_ce2   (sram_ce2),
   .sram_we_n  (sram_we_n),
   .sram_oe_n  (sram_oe_n)
);

// File: tb/test_frame_recorder.sv
module test_frame_recorder;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 3;
   localparam int FW         = 4;
   localparam int NS         = 3;
   localparam int MEM_N      = 2 ** (ADDR_W + 1);

   // vector table: pixels written, expected frames replayed, absolute index of oldest replayed frame
   localparam int NV = 8;
   localparam int    V_NPIX  [NV] = '{0, 2, 4, 9, 12, 13, 24, 26};
   localparam int    V_FRAMES[NV] = '{0, 0, 1, 2, 3, 2, 3, 2};
   localparam int    V_FIRST [NV] = '{0, 0, 0, 0, 0, 1, 3, 4};
   localparam string V_TAG   [NV] = '{"R12", "R6", "R6", "R6", "R7", "R8", "R4/R7", "R8"};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pix_valid = 1'b0;
   logic              pix_ready;
   logic [15:0]       pix_data = '0;
   logic              crash = 1'b0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [7:0]        out_data;
   logic [ADDR_W-1:0] sram_addr;
   logic [1:0]        sram_ce1_n;
   logic [1:0]        sram_ce2;
   logic              sram_we_n;
   logic              sram_oe_n;
   logic              sram_bhe_n;
   logic              sram_ble_n;
   wire  [15:0]       sram_dq;

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q [0:255];
   logic [7:0] got_q [0:255];

   always #(CLK_PERIOD / 2) clk = ~clk;

   frame_recorder #(
      .ADDR_W      (ADDR_W),
      .FRAME_WORDS (FW),
      .NUM_SLOTS   (NS)
   ) i_frame_recorder (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_valid  (pix_valid),
      .pix_ready  (pix_ready),
      .pix_data   (pix_data),
      .crash      (crash),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .sram_addr  (sram_addr),
      .sram_ce1_n (sram_ce1_n),
      .sram_ce2   (sram_ce2),
      .sram_we_n  (sram_we_n),
      .sram_oe_n  (sram_oe_n),
      .sram_bhe_n (sram_bhe_n),
      .sram_ble_n (sram_ble_n),
      .sram_dq    (sram_dq)
   );

   // two-chip asynchronous SRAM model; mem index = {chip, address}
   logic [15:0] mem [0:MEM_N-1];
   logic sel0, sel1;
   assign sel0 = !sram_ce1_n[0] && sram_ce2[0];
   assign sel1 = !sram_ce1_n[1] && sram_ce2[1];
   assign sram_dq = (sram_oe_n === 1'b0 && sram_we_n === 1'b1 && (sel0 || sel1))
                    ? mem[{sel1, sram_addr}] : 'z;

   initial begin
      for (int i = 0; i < MEM_N; i++) mem[i] = '0;
   end

   always @(posedge sram_we_n) begin
      if (sel0 === 1'b1 || sel1 === 1'b1) begin
         mem[{sel1, sram_addr}] = sram_dq;
         we_cnt++;
      end
   end

   function automatic logic [15:0] pv(input int k);
      return {8'(k * 7 + 3), 8'(k ^ 192)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      crash = 1'b0;
      pix_valid = 1'b0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_pix(input logic [15:0] d);
      @(negedge clk);
      while (!pix_ready) @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = d;
      @(posedge clk);
      #1 pix_valid = 1'b0;
   endtask

   task automatic build_exp(input int frames, input int first, output int len);
      int n = 0;
      for (int f = 0; f < frames; f++) begin
         exp_q[n] = 8'hA5; n++;
         exp_q[n] = 8'(f); n++;
         for (int w = 0; w < FW; w++) begin
            logic [15:0] p;
            p = pv((first + f) * FW + w);
            exp_q[n] = p[15:8]; n++;
            exp_q[n] = p[7:0];  n++;
         end
      end
      len = n;
   endtask

   task automatic drain(input int frames, input int first, input string tag);
      int len;
      int got = 0;
      int bad_hold = 0;
      int extra = 0;
      int mism = -1;
      int cyc = 0;
      logic lv = 1'b0;
      logic lr = 1'b0;
      logic [7:0] ld = 8'h00;
      build_exp(frames, first, len);
      while (got < len && cyc < 3000) begin
         @(negedge clk);
         if (lv && !lr && (!out_valid || out_data != ld)) bad_hold++;
         out_ready = ((cyc % 3) != 2);
         if (out_valid && out_ready) begin
            got_q[got] = out_data;
            got++;
         end
         lv = out_valid; lr = out_ready; ld = out_data;
         cyc++;
      end
      for (int i = 0; i < got; i++)
         if (mism < 0 && got_q[i] !== exp_q[i]) mism = i;
      chk(got == len, tag, "replayed byte count", got, len);
      if (mism >= 0)
         chk(1'b0, tag, "R9 byte mismatch", int'(got_q[mism]), int'(exp_q[mism]));
      else
         chk(1'b1, tag, "R9 byte stream", 0, 0);
      chk(bad_hold == 0, "R10", "stalled byte changed", bad_hold, 0);
      out_ready = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (out_valid) extra++;
      end
      chk(extra == 0, "R12", "bytes after stream end", extra, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      do_reset();
      // R1 reset state
      chk(pix_ready == 1'b1, "R1", "pix_ready after reset", int'(pix_ready), 1);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      chk(sram_ce1_n == 2'b11 && sram_ce2 == 2'b00, "R1", "chip enables after reset",
          int'({sram_ce1_n, sram_ce2}), 12);
      chk(sram_we_n && sram_oe_n, "R1", "we_n/oe_n after reset",
          int'({sram_we_n, sram_oe_n}), 3);

      for (int v = 0; v < NV; v++) begin
         do_reset();
         base = we_cnt;
         for (int k = 0; k < V_NPIX[v]; k++) send_pix(pv(k));
         repeat (4) @(negedge clk);
         chk(we_cnt - base == V_NPIX[v], "R2", "write pulses per pixel", we_cnt - base, V_NPIX[v]);
         crash = 1'b1;
         drain(V_FRAMES[v], V_FIRST[v], V_TAG[v]);
      end

      // R3: slot 2 (global 8..11) lands in chip 1, slot 1 in chip 0
      do_reset();
      for (int k = 0; k < 12; k++) send_pix(pv(k));
      repeat (4) @(negedge clk);
      chk(mem[8] === pv(8), "R3", "slot2 word0 in chip1 addr0", int'(mem[8]), int'(pv(8)));
      chk(mem[7] === pv(7), "R3", "slot1 word3 in chip0 addr7", int'(mem[7]), int'(pv(7)));
      // R4: two more pixels overwrite slot 0 from the start
      send_pix(pv(12));
      send_pix(pv(13));
      repeat (4) @(negedge clk);
      chk(mem[0] === pv(12) && mem[1] === pv(13), "R4", "wrap to slot 0",
          int'(mem[1]), int'(pv(13)));
      crash = 1'b1;
      drain(2, 1, "R8");

      // R5: trigger while a write is in flight
      do_reset();
      base = we_cnt;
      for (int k = 0; k < 3; k++) send_pix(pv(k));
      send_pix(pv(3));
      crash = 1'b1;
      repeat (2) @(negedge clk);
      crash = 1'b0;
      chk(pix_ready == 1'b0, "R5", "pix_ready after trigger", int'(pix_ready), 0);
      pix_valid = 1'b1;
      pix_data  = 16'hDEAD;
      repeat (6) @(negedge clk);
      pix_valid = 1'b0;
      chk(we_cnt - base == 4, "R5", "in-flight write done, no more", we_cnt - base, 4);
      drain(1, 0, "R5");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule